// File: doc/BRIEF.md
# Viterbi Compare-Select-Store Unit

This block performs the compare-select half of a Viterbi add-compare-select step. Upstream adders pack two candidate path metrics into one 32-bit accumulator word, one metric in each 16-bit half. On a start strobe the unit compares the two halves and registers the larger one as store data. It outputs that data with a store address and a one-cycle write enable, so that a data memory can record the surviving metric.

The unit also records which half survived. It writes the decision to a test/control flag and shifts the same bit into a 16-bit transition history register. A traceback routine reads that register later to rebuild the survivor path. Software can clear the flag, and it can clear or preset the history register through dedicated inputs. The flag and the history register are both visible at the ports.

Top module: `vcss_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `st_we_o`, `tc_o`, `trn_o`, `st_data_o` and `st_addr_o` are all zero.
- R2: When the upper half of `acc_i` is strictly greater than the lower half, the cycle after the start strobe shows the upper half on `st_data_o`, and `tc_o` is 0.
- R3: When the upper half is less than or equal to the lower half (equality included), the cycle after the start strobe shows the lower half on `st_data_o`, and `tc_o` is 1.
- R4: The halves are compared as signed two's-complement numbers. 0x8000 loses to 0x0001, and 0x7FFF beats 0xFFFF.
- R5: `st_we_o` is high for exactly the one cycle after each sampled start strobe. In that cycle `st_addr_o` equals the `addr_i` value presented with the strobe.
- R6: Each operation shifts `trn_o` left by one place and puts the new flag value into bit 0. The old bit 15 is dropped. This happens on the same edge that raises `st_we_o`.
- R7: Start strobes on consecutive cycles each produce their own store pulse and their own history shift, with none lost.
- R8: When `trn_ld_i` is high, the history register takes `trn_ld_val_i`. If a start is sampled on the same edge, the loaded value is shifted and the new decision enters bit 0.
- R9: `trn_clr_i` zeroes the history register and takes priority over `trn_ld_i`. A start on the same edge shifts into the cleared value. `tc_clr_i` zeroes the flag unless a start on the same edge writes a new decision.
- R10: In a cycle with no start, load or clear, `tc_o`, `trn_o`, `st_data_o` and `st_addr_o` hold their values, and `st_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one compare-select-store operation |
| acc_i | input | 32 | Packed metrics: upper half and lower half |
| addr_i | input | 16 | Store address for this operation |
| trn_ld_i | input | 1 | Preset the history register |
| trn_ld_val_i | input | 16 | Value to preset into the history register |
| trn_clr_i | input | 1 | Clear the history register |
| tc_clr_i | input | 1 | Clear the decision flag |
| st_we_o | output | 1 | Store write enable, one cycle per operation |
| st_data_o | output | 16 | Surviving (larger) metric |
| st_addr_o | output | 16 | Store address |
| tc_o | output | 1 | Decision flag: 0 = upper half won, 1 = lower half won |
| trn_o | output | 16 | Transition history register |

## Verification
The comparison is driven with clear wins for each half, with equal halves, and with pairs that straddle the sign boundary. Equal halves show whether ties go to the lower word. The sign-boundary pairs separate a signed compare from an unsigned one. A long run of back-to-back strobes with pseudo-random metrics fills and overflows the history register, which shows that no operation is dropped and that the oldest bit leaves. Load and clear are applied both alone and on the same edge as a start, which separates the order of preset, clear and shift.

// File: rtl/vcss_pkg.sv
package vcss_pkg;
   // Decision encoding shared by the flag and history bits
   typedef enum logic {
      PICK_HIGH = 1'b0,
      PICK_LOW  = 1'b1
   } pick_e;
endpackage

// File: rtl/vcss_compare.sv
module vcss_compare
   import vcss_pkg::*;
#(
   parameter int HALF_W     = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [2*HALF_W-1:0] acc_i,
   output pick_e               pick_o,
   output logic [HALF_W-1:0]   winner_o
);
   localparam int ACC_W = 2 * HALF_W;

   logic [HALF_W-1:0] hi_w;
   logic [HALF_W-1:0] lo_w;
   logic              hi_wins;

   assign hi_w = acc_i[ACC_W-1:HALF_W];
   assign lo_w = acc_i[HALF_W-1:0];

   generate
      if (SIGNED_CMP) begin : g_signed
         assign hi_wins = $signed(hi_w) > $signed(lo_w);
      end else begin : g_unsigned
         assign hi_wins = hi_w > lo_w;
      end
   endgenerate

   // Ties go to the low word
   assign pick_o   = hi_wins ? PICK_HIGH : PICK_LOW;
   assign winner_o = hi_wins ? hi_w : lo_w;
endmodule

// File: rtl/vcss_history.sv
module vcss_history #(
   parameter int HIST_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              ld_i,
   input  logic [HIST_W-1:0] ld_val_i,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [HIST_W-1:0] hist_o
);
   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] base;
   logic [HIST_W-1:0] hist_d;

   // Clear beats preset; a shift then works on the resulting value
   always_comb begin
      if (clr_i)      base = '0;
      else if (ld_i)  base = ld_val_i;
      else            base = hist_q;
      hist_d = shift_i ? {base[HIST_W-2:0], bit_i} : base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= hist_d;
   end

   assign hist_o = hist_q;
endmodule

// File: rtl/vcss_store.sv
module vcss_store
   import vcss_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic [HALF_W-1:0] data_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  pick_e             pick_i,
   input  logic              flag_clr_i,
   output logic              we_o,
   output logic [HALF_W-1:0] data_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              tc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_o   <= 1'b0;
         data_o <= '0;
         addr_o <= '0;
         tc_o   <= 1'b0;
      end else begin
         we_o <= fire_i;
         if (fire_i) begin
            data_o <= data_i;
            addr_o <= addr_i;
            tc_o   <= (pick_i == PICK_LOW);
         end else if (flag_clr_i) begin
            tc_o   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vcss_unit.sv
module vcss_unit
   import vcss_pkg::*;
#(
   parameter int HALF_W     = 16,
   parameter int ADDR_W     = 16,
   parameter int HIST_W     = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [2*HALF_W-1:0] acc_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                trn_ld_i,
   input  logic [HIST_W-1:0]   trn_ld_val_i,
   input  logic                trn_clr_i,
   input  logic                tc_clr_i,
   output logic                st_we_o,
   output logic [HALF_W-1:0]   st_data_o,
   output logic [ADDR_W-1:0]   st_addr_o,
   output logic                tc_o,
   output logic [HIST_W-1:0]   trn_o
);
   localparam int ACC_W = 2 * HALF_W;

   generate
      if (HALF_W < 2) begin : g_bad_half
         $error("vcss_unit: HALF_W must be at least 2");
      end
      if (HIST_W < 2) begin : g_bad_hist
         $error("vcss_unit: HIST_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("vcss_unit: ADDR_W must be at least 1");
      end
   endgenerate

   pick_e             pick;
   logic [HALF_W-1:0] winner;
   logic              tc_q;

   vcss_compare #(.HALF_W(HALF_W), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .acc_i    (acc_i[ACC_W-1:0]),
      .pick_o   (pick),
      .winner_o (winner)
   );

   vcss_store #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (start_i),
      .data_i     (winner),
      .addr_i     (addr_i),
      .pick_i     (pick),
      .flag_clr_i (tc_clr_i),
      .we_o       (st_we_o),
      .data_o     (st_data_o),
      .addr_o     (st_addr_o),
      .tc_o       (tc_q)
   );

   vcss_history #(.HIST_W(HIST_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (trn_clr_i),
      .ld_i     (trn_ld_i),
      .ld_val_i (trn_ld_val_i),
      .shift_i  (start_i),
      .bit_i    (pick == PICK_LOW),
      .hist_o   (trn_o)
   );

   assign tc_o = tc_q;
endmodule

// File: rtl/vcss_unit_chk.sv
module vcss_unit_chk #(
   parameter int HALF_W     = 16,
   parameter int ADDR_W     = 16,
   parameter int HIST_W     = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic [2*HALF_W-1:0] acc_i,
   input logic [ADDR_W-1:0]   addr_i,
   input logic                trn_ld_i,
   input logic [HIST_W-1:0]   trn_ld_val_i,
   input logic                trn_clr_i,
   input logic                tc_clr_i,
   input logic                st_we_o,
   input logic [HALF_W-1:0]   st_data_o,
   input logic [ADDR_W-1:0]   st_addr_o,
   input logic                tc_o,
   input logic [HIST_W-1:0]   trn_o
);
   localparam int ACC_W = 2 * HALF_W;

   assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> st_we_o);
   assert_we_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !st_we_o);
   assert_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> st_addr_o == $past(addr_i));
   assert_tc_choice_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> tc_o == (st_data_o == $past(acc_i[HALF_W-1:0])));
   assert_trn_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !trn_ld_i && !trn_clr_i) |=>
         trn_o == {$past(trn_o[HIST_W-2:0]), tc_o});
   assert_trn_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trn_ld_i && !trn_clr_i && !start_i) |=> trn_o == $past(trn_ld_val_i));
   assert_trn_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trn_clr_i && !start_i) |=> trn_o == '0);
   assert_tc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_clr_i && !start_i) |=> !tc_o);
   assert_tc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !tc_clr_i) |=> $stable(tc_o));

   generate
      if (SIGNED_CMP) begin : g_signed_chk
         assert_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
            start_i |=>
               ($signed(st_data_o) >= $signed($past(acc_i[ACC_W-1:HALF_W]))) &&
               ($signed(st_data_o) >= $signed($past(acc_i[HALF_W-1:0]))));
      end else begin : g_unsigned_chk
         assert_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
            start_i |=>
               (st_data_o >= $past(acc_i[ACC_W-1:HALF_W])) &&
               (st_data_o >= $past(acc_i[HALF_W-1:0])));
      end
   endgenerate
endmodule

bind vcss_unit vcss_unit_chk #(
   .HALF_W(HALF_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W), .SIGNED_CMP(SIGNED_CMP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .acc_i(acc_i), .addr_i(addr_i),
   .trn_ld_i(trn_ld_i), .trn_ld_val_i(trn_ld_val_i), .trn_clr_i(trn_clr_i),
   .tc_clr_i(tc_clr_i), .st_we_o(st_we_o), .st_data_o(st_data_o),
   .st_addr_o(st_addr_o), .tc_o(tc_o), .trn_o(trn_o)
);

// File: tb/vcss_unit_test.sv
module vcss_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] acc_i = '0;
   logic [15:0] addr_i = '0;
   logic        trn_ld_i = 1'b0;
   logic [15:0] trn_ld_val_i = '0;
   logic        trn_clr_i = 1'b0;
   logic        tc_clr_i = 1'b0;
   logic        st_we_o;
   logic [15:0] st_data_o;
   logic [15:0] st_addr_o;
   logic        tc_o;
   logic [15:0] trn_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference state
   logic        m_we = 1'b0;
   logic [15:0] m_data = '0;
   logic [15:0] m_addr = '0;
   logic        m_tc = 1'b0;
   logic [15:0] m_trn = '0;

   always #10 clk = ~clk;

   vcss_unit uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .acc_i(acc_i), .addr_i(addr_i),
      .trn_ld_i(trn_ld_i), .trn_ld_val_i(trn_ld_val_i), .trn_clr_i(trn_clr_i),
      .tc_clr_i(tc_clr_i), .st_we_o(st_we_o), .st_data_o(st_data_o),
      .st_addr_o(st_addr_o), .tc_o(tc_o), .trn_o(trn_o)
   );

   task automatic compare(input string tag);
      checks++;
      if (st_we_o !== m_we || st_data_o !== m_data || st_addr_o !== m_addr ||
          tc_o !== m_tc || trn_o !== m_trn) begin
         errors++;
         $display("FAIL %s: got we=%b data=%h addr=%h tc=%b trn=%h exp we=%b data=%h addr=%h tc=%b trn=%h",
                  tag, st_we_o, st_data_o, st_addr_o, tc_o, trn_o,
                  m_we, m_data, m_addr, m_tc, m_trn);
      end
   endtask

   // One cycle: drive at falling edge, model at rising edge, check at next falling edge
   task automatic step(input string tag, input bit st, input logic [31:0] acc,
                       input logic [15:0] ad, input bit ld, input logic [15:0] ldv,
                       input bit hclr, input bit fclr);
      logic [15:0] base;
      logic [15:0] hi;
      logic [15:0] lo;
      start_i = st; acc_i = acc; addr_i = ad;
      trn_ld_i = ld; trn_ld_val_i = ldv; trn_clr_i = hclr; tc_clr_i = fclr;
      @(posedge clk);
      base = hclr ? 16'h0 : (ld ? ldv : m_trn);
      if (fclr) m_tc = 1'b0;
      if (st) begin
         hi = acc[31:16];
         lo = acc[15:0];
         if (int'($signed(hi)) > int'($signed(lo))) begin
            m_tc = 1'b0; m_data = hi;
         end else begin
            m_tc = 1'b1; m_data = lo;
         end
         m_addr = ad;
         m_we = 1'b1;
         m_trn = {base[14:0], m_tc};
      end else begin
         m_we = 1'b0;
         m_trn = base;
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] lfsr;
      lfsr = 32'hACE1_1234;
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1'b1;
      step("R1 after reset", 0, 32'h0, 16'h0, 0, 16'h0, 0, 0);

      // R2: high word wins
      step("R2 high wins", 1, 32'h0100_0050, 16'h0010, 0, 16'h0, 0, 0);
      step("R10 idle hold", 0, 32'h0000_7777, 16'h0099, 0, 16'h0, 0, 0);
      // R3: low wins, and ties go low
      step("R3 low wins", 1, 32'h0020_0300, 16'h0011, 0, 16'h0, 0, 0);
      step("R3 equal", 1, 32'h1234_1234, 16'h0012, 0, 16'h0, 0, 0);
      // R4: signed boundaries
      step("R4 neg high", 1, 32'h8000_0001, 16'h0013, 0, 16'h0, 0, 0);
      step("R4 neg low", 1, 32'h7FFF_FFFF, 16'h0014, 0, 16'h0, 0, 0);
      step("R4 both neg", 1, 32'hFFFE_FFFF, 16'h0015, 0, 16'h0, 0, 0);
      step("R5 we drops", 0, 32'h0, 16'h0, 0, 16'h0, 0, 0);

      // R7 / R6: long back-to-back run overflowing the history
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step("R7 back-to-back R6 shift", 1, lfsr, 16'(i * 3 + 1), 0, 16'h0, 0, 0);
      end

      // R8: preset alone and with a start
      step("R8 load", 0, 32'h0, 16'h0, 1, 16'hA5C3, 0, 0);
      step("R10 hold after load", 0, 32'h0, 16'h0, 0, 16'h0, 0, 0);
      step("R8 load with start", 1, 32'h0001_0002, 16'h0020, 1, 16'h8001, 0, 0);

      // R9: clears and priorities
      step("R9 clear beats load", 0, 32'h0, 16'h0, 1, 16'hFFFF, 1, 0);
      step("R8 reload", 0, 32'h0, 16'h0, 1, 16'h0F0F, 0, 0);
      step("R9 clear with start", 1, 32'h0001_0002, 16'h0021, 0, 16'h0, 1, 0);
      step("R9 flag clear", 0, 32'h0, 16'h0, 0, 16'h0, 0, 1);
      step("R3 set flag", 1, 32'h0000_0005, 16'h0022, 0, 16'h0, 0, 0);
      step("R9 start beats flag clear", 1, 32'h0000_0009, 16'h0023, 0, 16'h0, 0, 1);
      step("R9 flag clear alone", 0, 32'h0, 16'h0, 0, 16'h0, 0, 1);
      for (int i = 0; i < 3; i++)
         step("R10 idle", 0, 32'hDEAD_BEEF, 16'hFFFF, 0, 16'h0, 0, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule